// File: doc/BRIEF.md
# Compact Branch Resolver

This unit resolves control transfers written in a 16-bit compact instruction encoding. Each request carries one 32-bit fetch word holding two consecutive halfwords, an endianness select, the fetch PC of the current halfword, the four condition flags and the caller's current link value. The unit picks the current and following halfwords and classifies the current one. It then reports whether control moves, where it moves to, what the link value becomes, and whether the encoding is undefined.

There are three kinds of transfer. A conditional branch has an 8-bit displacement and a 4-bit condition. An unconditional branch has an 11-bit displacement. A call is split across two halfwords: a prefix that builds the upper part of the target in the link value, and a suffix that jumps and saves the return address. When the suffix is the halfword right after the prefix in the same fetch word, both are resolved in one step. A suffix that arrives alone uses the link value supplied with it. Any encoding that is not a transfer passes through with every flag low.

Requests enter on a valid/ready handshake and results leave on another, through one output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result is valid on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and new requests are refused.

Top module: `brres_top`

## Requirements
- R1: With `big_endian` high, the current halfword is `fetch_word[31:16]` and the following halfword is `fetch_word[15:0]`. With it low, the two halves swap roles.
- R2: A current halfword whose bits [15:12] are 4'hD is a conditional branch. Its condition code is bits [11:8] and its displacement is bits [7:0]. Codes 0..13 test: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). When the test passes, `taken` is high and `next_pc` = pc + 4 + sign-extended displacement × 2.
- R3: In the conditional form, code 14 raises `undef`. Code 15 is a service call: neither `taken` nor `undef` is raised.
- R4: Bits [15:11] = 28 is an unconditional branch. It is always taken, with `next_pc` = pc + 4 + sign-extended bits [10:0] × 2.
- R5: Bits [15:11] = 30 is a call prefix. Alone, it raises `link_we` with `link_out` = pc + 4 + (sign-extended bits [10:0] shifted left by 12), and is not taken.
- R6: When a prefix is followed in the same word by a halfword with bits [15:11] = 31, both are resolved together. `taken` is high, `next_pc` = prefix link value + suffix bits [10:0] × 2, `link_out` = (pc + 4) | 1, and `link_we` is high.
- R7: A current halfword with bits [15:11] = 31 is a lone call suffix. `taken` is high, `next_pc` = `link_in` + bits [10:0] × 2, `link_out` = (pc + 2) | 1, and `link_we` is high.
- R8: Bits [15:11] = 29 raises `undef`. An undefined result never raises `taken` or `link_we`.
- R9: `flush` is high exactly when `taken` is high. A result that is not taken gives `next_pc` = pc + 2. Whenever `link_we` is low, `link_out` equals `link_in`. Any other encoding gives all flags low.
- R10: A result is valid one cycle after its request is accepted. `in_ready` = !out_valid | out_ready. A stalled result holds stable. While `out_valid` is low, `taken`, `flush`, `link_we` and `undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| fetch_word | input | 32 | Two consecutive halfwords |
| big_endian | input | 1 | Selects which half is current |
| pc | input | ADDR_W | Fetch PC of the current halfword |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| link_in | input | ADDR_W | Current link value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| taken | output | 1 | Control moves to `next_pc` |
| next_pc | output | ADDR_W | Target, or pc + 2 when not taken |
| link_out | output | ADDR_W | New link value |
| link_we | output | 1 | Write `link_out` to the link register |
| flush | output | 1 | Discard younger fetched work |
| undef | output | 1 | Encoding is undefined |

## Verification
The assertions assume that request fields stay fixed while `in_valid` is high and `in_ready` is low, and that `pc` is halfword aligned. The driver sets every request field on a falling edge and holds it until the request is taken. All PCs it uses are even. The consumer's `out_ready` follows an irregular pattern, so results are stalled in some cycles and drained in the same cycle as a new acceptance in others. This exercises the hold and pass-through rules without breaking the input assumptions.

// File: rtl/brres_pkg.sv
package brres_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int HALF_W = 16;
  localparam int OP_W   = 5;

  typedef enum logic [2:0] {
    K_OTHER,
    K_BCOND,
    K_BRA,
    K_HOLE,
    K_LPRE,
    K_LSUF
  } kind_e;

  localparam logic [OP_W-1:0] OP_BRA  = 5'd28;
  localparam logic [OP_W-1:0] OP_HOLE = 5'd29;
  localparam logic [OP_W-1:0] OP_LPRE = 5'd30;
  localparam logic [OP_W-1:0] OP_LSUF = 5'd31;
  localparam logic [3:0]      HI_BCOND = 4'hD;
  localparam logic [3:0]      CC_UNDEF = 4'hE;
  localparam logic [3:0]      CC_SVC   = 4'hF;

  function automatic kind_e classify(input logic [HALF_W-1:0] h);
    kind_e k;
    if (h[15:12] == HI_BCOND)              k = K_BCOND;
    else if (h[15:11] == OP_BRA)           k = K_BRA;
    else if (h[15:11] == OP_HOLE)          k = K_HOLE;
    else if (h[15:11] == OP_LPRE)          k = K_LPRE;
    else if (h[15:11] == OP_LSUF)          k = K_LSUF;
    else                                   k = K_OTHER;
    return k;
  endfunction
endpackage

// File: rtl/brres_halfsel.sv
module brres_halfsel
  import brres_pkg::*;
(
  input  logic [2*HALF_W-1:0] fetch_word,
  input  logic                big_endian,
  output logic [HALF_W-1:0]   cur_half,
  output logic [HALF_W-1:0]   nxt_half
);
  timeunit 1ns; timeprecision 1ps;

  logic [HALF_W-1:0] upper, lower;
  assign upper = fetch_word[2*HALF_W-1:HALF_W];
  assign lower = fetch_word[HALF_W-1:0];

  always_comb begin
    if (big_endian) begin
      cur_half = upper;
      nxt_half = lower;
    end else begin
      cur_half = lower;
      nxt_half = upper;
    end
  end
endmodule

// File: rtl/brres_cond.sv
module brres_cond (
  input  logic [3:0] code,
  input  logic       fn,
  input  logic       fz,
  input  logic       fc,
  input  logic       fv,
  output logic       pass
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NCODE = 16;
  localparam int NPAIR = 7;

  logic [NCODE-1:0] hit;
  logic             nv_same;

  assign nv_same = (fn == fv);

  always_comb begin
    hit[0]  = fz;
    hit[1]  = ~fz;
    hit[2]  = fc;
    hit[3]  = ~fc;
    hit[4]  = fn;
    hit[5]  = ~fn;
    hit[6]  = fv;
    hit[7]  = ~fv;
    hit[8]  = fc & ~fz;
    hit[9]  = ~fc | fz;
    hit[10] = nv_same;
    hit[11] = ~nv_same;
    hit[12] = ~fz & nv_same;
    hit[13] = fz | ~nv_same;
    hit[14] = 1'b0;
    hit[15] = 1'b0;
  end

  assign pass = hit[code];

  // R2: each even/odd condition pair tests opposite outcomes
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    always_comb begin
      a_r2_pair_complement: assert (hit[2*k] != hit[2*k+1])
        else $error("condition pair %0d not complementary", k);
    end
  end
endmodule

// File: rtl/brres_decode.sv
module brres_decode
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [HALF_W-1:0] cur_half,
  input  logic [HALF_W-1:0] nxt_half,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] link_in,
  input  logic              fn,
  input  logic              fz,
  input  logic              fc,
  input  logic              fv,
  output logic              taken,
  output logic              undef,
  output logic              link_we,
  output logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] link_out
);
  timeunit 1ns; timeprecision 1ps;

  localparam int D8_W  = 8;
  localparam int D11_W = 11;
  localparam int HI_SH = 12;
  localparam int EXT8  = ADDR_W - D8_W - 1;
  localparam int EXT11 = ADDR_W - D11_W - 1;
  localparam int EXTHI = ADDR_W - D11_W - HI_SH;

  kind_e             kind;
  logic              cond_ok;
  logic              fuse;
  logic [3:0]        code;
  logic [ADDR_W-1:0] pc_p2, pc_p4;
  logic [ADDR_W-1:0] disp8, disp11, upper_part, low_cur, low_nxt;
  logic [ADDR_W-1:0] pre_link;

  assign kind  = classify(cur_half);
  assign code  = cur_half[11:8];
  assign fuse  = (nxt_half[15:11] == OP_LSUF);
  assign pc_p2 = pc + ADDR_W'(2);
  assign pc_p4 = pc + ADDR_W'(4);

  assign disp8      = {{EXT8{cur_half[7]}}, cur_half[7:0], 1'b0};
  assign disp11     = {{EXT11{cur_half[10]}}, cur_half[10:0], 1'b0};
  assign upper_part = {{EXTHI{cur_half[10]}}, cur_half[10:0], {HI_SH{1'b0}}};
  assign low_cur    = {{EXT11{1'b0}}, cur_half[10:0], 1'b0};
  assign low_nxt    = {{EXT11{1'b0}}, nxt_half[10:0], 1'b0};
  assign pre_link   = pc_p4 + upper_part;

  brres_cond u_cond (
    .code (code),
    .fn   (fn),
    .fz   (fz),
    .fc   (fc),
    .fv   (fv),
    .pass (cond_ok)
  );

  always_comb begin
    taken    = 1'b0;
    undef    = 1'b0;
    link_we  = 1'b0;
    next_pc  = pc_p2;
    link_out = link_in;
    unique case (kind)
      K_BCOND: begin
        if (code == CC_UNDEF) begin
          undef = 1'b1;
        end else if (code != CC_SVC && cond_ok) begin
          taken   = 1'b1;
          next_pc = pc_p4 + disp8;
        end
      end
      K_BRA: begin
        taken   = 1'b1;
        next_pc = pc_p4 + disp11;
      end
      K_HOLE: begin
        undef = 1'b1;
      end
      K_LPRE: begin
        link_we  = 1'b1;
        link_out = pre_link;
        if (fuse) begin
          taken    = 1'b1;
          next_pc  = pre_link + low_nxt;
          link_out = pc_p4 | ADDR_W'(1);
        end
      end
      K_LSUF: begin
        taken    = 1'b1;
        link_we  = 1'b1;
        next_pc  = link_in + low_cur;
        link_out = pc_p2 | ADDR_W'(1);
      end
      default: begin
      end
    endcase
  end

  // R8: undefined encodings never redirect or write the link value
  always_comb begin
    a_r8_undef_quiet: assert (!(undef && (taken || link_we)))
      else $error("undefined encoding with side effect");
  end
endmodule

// File: rtl/brres_top.sv
module brres_top
  import brres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*HALF_W-1:0] fetch_word,
  input  logic                big_endian,
  input  logic [ADDR_W-1:0]   pc,
  input  logic                flag_n,
  input  logic                flag_z,
  input  logic                flag_c,
  input  logic                flag_v,
  input  logic [ADDR_W-1:0]   link_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                taken,
  output logic [ADDR_W-1:0]   next_pc,
  output logic [ADDR_W-1:0]   link_out,
  output logic                link_we,
  output logic                flush,
  output logic                undef
);
  timeunit 1ns; timeprecision 1ps;

  logic [HALF_W-1:0] cur_half, nxt_half;
  logic              d_taken, d_undef, d_lwe;
  logic [ADDR_W-1:0] d_npc, d_link;
  logic              accept;

  logic              v_q, tk_q, fl_q, lw_q, ud_q;
  logic [ADDR_W-1:0] npc_q, lnk_q;

  brres_halfsel u_sel (
    .fetch_word (fetch_word),
    .big_endian (big_endian),
    .cur_half   (cur_half),
    .nxt_half   (nxt_half)
  );

  brres_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cur_half (cur_half),
    .nxt_half (nxt_half),
    .pc       (pc),
    .link_in  (link_in),
    .fn       (flag_n),
    .fz       (flag_z),
    .fc       (flag_c),
    .fv       (flag_v),
    .taken    (d_taken),
    .undef    (d_undef),
    .link_we  (d_lwe),
    .next_pc  (d_npc),
    .link_out (d_link)
  );

  assign in_ready = !v_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      tk_q  <= 1'b0;
      fl_q  <= 1'b0;
      lw_q  <= 1'b0;
      ud_q  <= 1'b0;
      npc_q <= '0;
      lnk_q <= '0;
    end else if (accept) begin
      v_q   <= 1'b1;
      tk_q  <= d_taken;
      fl_q  <= d_taken;
      lw_q  <= d_lwe;
      ud_q  <= d_undef;
      npc_q <= d_npc;
      lnk_q <= d_link;
    end else if (out_ready) begin
      v_q  <= 1'b0;
      tk_q <= 1'b0;
      fl_q <= 1'b0;
      lw_q <= 1'b0;
      ud_q <= 1'b0;
    end
  end

  assign out_valid = v_q;
  assign taken     = tk_q;
  assign flush     = fl_q;
  assign link_we   = lw_q;
  assign undef     = ud_q;
  assign next_pc   = npc_q;
  assign link_out  = lnk_q;

  // R10: an accepted request yields a result on the next cycle
  a_r10_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R10: a stalled result holds every field
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(next_pc) &&
      $stable(link_out) && $stable(taken) && $stable(link_we) && $stable(undef)));

  // R10: no side-effect flag while the output is empty
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(taken || flush || link_we || undef));

  // R9: flush accompanies every taken result and nothing else
  a_r9_flush_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flush == taken));

  // R8: registered undefined result carries no redirect
  a_r8_undef_registered: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!taken && !link_we));
endmodule

// File: tb/brres_top_test.sv
module brres_top_test;
  timeunit 1ns; timeprecision 1ps;

  typedef struct packed {
    logic        taken;
    logic [31:0] npc;
    logic [31:0] lnk;
    logic        lwe;
    logic        und;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] fetch_word = '0;
  logic        big_endian = 1'b0;
  logic [31:0] pc = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic [31:0] link_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        taken;
  logic [31:0] next_pc;
  logic [31:0] link_out;
  logic        link_we;
  logic        flush;
  logic        undef;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  exp_t  q[$];
  string tq[$];

  always #5 clk = ~clk;

  brres_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fetch_word(fetch_word), .big_endian(big_endian), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .link_in(link_in), .out_valid(out_valid), .out_ready(out_ready),
    .taken(taken), .next_pc(next_pc), .link_out(link_out),
    .link_we(link_we), .flush(flush), .undef(undef)
  );

  function automatic logic cond_eval(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(input logic [15:0] c, input logic [15:0] n,
                                 input logic [31:0] p, input logic [3:0] f,
                                 input logic [31:0] lk);
    exp_t e;
    int   d;
    e.taken = 1'b0; e.npc = p + 32'd2; e.lnk = lk; e.lwe = 1'b0; e.und = 1'b0;
    case (c[15:11])
      5'd26, 5'd27: begin
        if (c[11:8] == 4'd14) e.und = 1'b1;
        else if (c[11:8] != 4'd15 && cond_eval(c[11:8], f)) begin
          d = int'($signed(c[7:0]));
          e.taken = 1'b1;
          e.npc = p + 32'(4 + 2 * d);
        end
      end
      5'd28: begin
        d = int'($signed(c[10:0]));
        e.taken = 1'b1;
        e.npc = p + 32'(4 + 2 * d);
      end
      5'd29: e.und = 1'b1;
      5'd30: begin
        d = int'($signed(c[10:0]));
        e.lwe = 1'b1;
        e.lnk = p + 32'(4 + d * 4096);
        if (n[15:11] == 5'd31) begin
          e.taken = 1'b1;
          e.npc = e.lnk + 32'(2 * int'(n[10:0]));
          e.lnk = (p + 32'd4) | 32'd1;
        end
      end
      5'd31: begin
        e.taken = 1'b1;
        e.lwe = 1'b1;
        e.npc = lk + 32'(2 * int'(c[10:0]));
        e.lnk = (p + 32'd2) | 32'd1;
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] c, input logic [15:0] n, input logic be,
                      input logic [31:0] p, input logic [3:0] f,
                      input logic [31:0] lk, input string tag);
    bit ok;
    q.push_back(model(c, n, p, f, lk));
    tq.push_back(tag);
    @(negedge clk);
    fetch_word = be ? {c, n} : {n, c};
    big_endian = be;
    pc = p;
    {flag_n, flag_z, flag_c, flag_v} = f;
    link_in = lk;
    in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    report(out_valid === 1'b1, "R10", "valid one cycle after accept", 32'(out_valid), 32'd1);
  endtask

  // consumer back-pressure pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      out_ready = (cyc % 5 != 1) && (cyc % 7 != 3);
    end
  end

  // monitor / scoreboard
  exp_t        e;
  string       tg;
  bit          stall_prev = 1'b0;
  logic [31:0] hold_npc, hold_lnk;
  logic [3:0]  hold_fl;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        report(out_valid && next_pc == hold_npc && link_out == hold_lnk &&
               {taken, flush, link_we, undef} == hold_fl,
               "R10", "stalled result held", next_pc, hold_npc);
      end
      stall_prev = out_valid && !out_ready;
      hold_npc = next_pc;
      hold_lnk = link_out;
      hold_fl  = {taken, flush, link_we, undef};
      if (!out_valid) begin
        report({taken, flush, link_we, undef} == 4'b0, "R10", "idle flags low",
               32'({taken, flush, link_we, undef}), 32'd0);
      end else if (out_ready) begin
        if (q.size() == 0) begin
          report(1'b0, "R10", "unexpected result", next_pc, 32'd0);
        end else begin
          e = q.pop_front();
          tg = tq.pop_front();
          report(taken == e.taken, tg, "taken", 32'(taken), 32'(e.taken));
          report(flush == e.taken, "R9", "flush", 32'(flush), 32'(e.taken));
          report(next_pc == e.npc, tg, "next_pc", next_pc, e.npc);
          report(link_out == e.lnk, tg, "link_out", link_out, e.lnk);
          report(link_we == e.lwe, tg, "link_we", 32'(link_we), 32'(e.lwe));
          report(undef == e.und, tg, "undef", 32'(undef), 32'(e.und));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    report(out_valid == 1'b0, "R10", "reset out_valid", 32'(out_valid), 32'd0);
    report(in_ready == 1'b1, "R10", "reset in_ready", 32'(in_ready), 32'd1);

    // R2 / R3 / R1: every condition code against every flag combination
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        send(16'hD000 | 16'(cc << 8) | 16'(((cc * 16 + f) * 37) & 8'hFF), 16'h1234,
             1'(f ^ cc), 32'h0000_4000 + 32'((cc * 16 + f) * 2), 4'(f), 32'hCAFE_0000,
             (cc >= 14) ? "R3" : "R2");
      end
    end
    send(16'hDF12, 16'h0000, 1'b0, 32'h100, 4'h0, 32'h55, "R3");

    // R4 unconditional: zero, max positive, most negative
    send(16'hE000, 16'h0000, 1'b0, 32'h0000_2000, 4'h0, 32'h0, "R4");
    send(16'hE3FF, 16'h0000, 1'b1, 32'h0000_2000, 4'hF, 32'h0, "R4");
    send(16'hE400, 16'h0000, 1'b0, 32'h0000_2000, 4'h5, 32'h0, "R4");

    // R5 lone prefix, R1 both orders
    send(16'hF123, 16'h0000, 1'b0, 32'h0001_0000, 4'h0, 32'h77, "R5");
    send(16'hF7FF, 16'hE800, 1'b1, 32'h0080_0000, 4'h0, 32'h77, "R5");
    send(16'hF400, 16'h2000, 1'b0, 32'h0080_0000, 4'h0, 32'h77, "R5");

    // R6 fused pair, both orders
    send(16'hF001, 16'hF8AB, 1'b0, 32'h0000_1000, 4'h0, 32'h99, "R6");
    send(16'hF7FE, 16'hFFFF, 1'b1, 32'h0040_0000, 4'h0, 32'h99, "R6");

    // R7 lone suffix
    send(16'hF812, 16'h0000, 1'b0, 32'h0000_3000, 4'h0, 32'h0002_0000, "R7");
    send(16'hFFFF, 16'hF000, 1'b1, 32'h0000_3002, 4'h0, 32'h1000_0004, "R7");

    // R8 undefined hole
    send(16'hE800, 16'h0000, 1'b0, 32'h500, 4'hF, 32'h12, "R8");
    send(16'hEFFF, 16'hF800, 1'b1, 32'h502, 4'h0, 32'h12, "R8");

    // R9 non-branch encodings
    send(16'h2000, 16'hF800, 1'b0, 32'h600, 4'h0, 32'hAB, "R9");
    send(16'h4770, 16'h0000, 1'b1, 32'h602, 4'h4, 32'hAB, "R9");
    send(16'hC0FF, 16'hD0FF, 1'b0, 32'h604, 4'h4, 32'hAB, "R9");

    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule